// File: doc/BRIEF.md
# Inbound Serial Frame Packer

This block builds the codec side of one inbound frame on a single serial data line. The line runs at the bit clock. A one-cycle frame-start pulse starts a frame of a fixed number of bit slots (500 by default). The frame opens with a 36-bit response word. Each active stream then follows in index order. A stream is sent as a 4-bit tag, a 6-bit length in bytes, and its sample bits. The sample bits are zero-padded up to the next byte boundary. Every slot after the last stream, up to the end of the frame, carries zero.

All inputs are captured at the edge where the frame-start pulse is seen, so they may change freely while the frame is being sent. Each stream is described by a tag, a sample width, a channel count and a block count. The payload size is width times channels times blocks, and the sample bits come from a per-stream data vector. Two flags are reported for each frame: an oversized stream that was rejected, and a frame whose content exceeds the slot budget.

Top module: `sdi_inbound_packer`

## Requirements
- R1: After reset, `sdi`, `len_err` and `overrun` are 0.
- R2: When `frame_start` is high at a rising edge, slot 0 appears on `sdi` after that same edge. Slot n appears after the n-th following edge. Slots 0 to 35 carry `rsp_word` bits 35 down to 0.
- R3: Streams follow the response in index order 0 to NUM_STR-1. Each stream is sent as its 4-bit tag (MSB first) and then its length in bytes as 6 bits (MSB first).
- R4: After the length field, a stream's payload bits are taken from its data vector starting at bit 503 and moving downward. This is MSB first within each sample.
- R5: The length equals ceil(payload_bits/8). Slots between the payload end and the byte boundary carry 0, whatever the data vector holds there.
- R6: A stream whose tag is 0 ends the stream list. Neither it nor any higher-index stream is sent.
- R7: A stream with zero payload bits is skipped, and the next stream follows directly.
- R8: A stream longer than 63 bytes is skipped and sets `len_err`. The flag holds from slot 0 until the next frame start.
- R9: Slots after the last stream up to slot 499 carry 0. After the frame ends, `sdi` stays 0 until the next frame start.
- R10: If the total of 36 plus 10+8×length over the sent streams exceeds 500, `overrun` is set for that frame. Only the first 500 bits are sent.
- R11: A frame start during a frame abandons that frame and restarts at slot 0 with the newly captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame start pulse; captures all inputs |
| rsp_word | input | 36 | Response word for the frame |
| strm_tag | input | NUM_STR*4 | Per-stream tag; 0 ends the list |
| strm_width | input | NUM_STR*6 | Per-stream sample width in bits |
| strm_chans | input | NUM_STR*5 | Per-stream channel count |
| strm_blocks | input | NUM_STR*3 | Per-stream sample block count |
| strm_data | input | NUM_STR*504 | Per-stream payload bits, first bit at the top |
| sdi | output | 1 | Serial inbound data line |
| len_err | output | 1 | A stream above 63 bytes was dropped this frame |
| overrun | output | 1 | Frame content exceeded the slot budget |

## Verification
Some properties are checked on every cycle: slot 0 carrying the response MSB right after a frame start, the line staying low when idle, in the fill region and in pad slots, the slot counter staying inside the frame, every sent stream having a nonzero tag and length, and the flags holding still between frame starts. Other behaviour can only be shown by the bench scenarios, which compare whole 500-slot frames against an independent model. These cover the exact ordering of tag, length and payload bits, the end of the list at a zero tag, the skipping of empty and oversized streams, truncation on overrun, and a restart in mid-frame.

// File: rtl/sip_pkg.sv
package sip_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESP,
    PH_TAG,
    PH_LEN,
    PH_DATA,
    PH_FILL
  } phase_e;

  // lowest set index of mask at or above 'from'; returns n when none
  function automatic int next_set(input logic [31:0] mask, input int from, input int n);
    int r;
    r = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && i >= from && mask[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/sip_stream_sizer.sv
module sip_stream_sizer #(
  parameter int BLK_W   = 3,
  parameter int CH_W    = 5,
  parameter int SW_W    = 6,
  parameter int BITS_W  = 14,
  parameter int BYTES_W = 12
) (
  input  logic [BLK_W-1:0]   blocks,
  input  logic [CH_W-1:0]    chans,
  input  logic [SW_W-1:0]    width,
  output logic [BITS_W-1:0]  bits,
  output logic [BYTES_W-1:0] bytes
);

  logic [BITS_W:0] rounded;

  assign bits    = BITS_W'(blocks) * BITS_W'(chans) * BITS_W'(width);
  assign rounded = {1'b0, bits} + (BITS_W+1)'(7);
  assign bytes   = BYTES_W'(rounded[BITS_W:3]);

endmodule

// File: rtl/sip_frame_budget.sv
module sip_frame_budget #(
  parameter int NUM_STR    = 4,
  parameter int TAG_W      = 4,
  parameter int LEN_W      = 6,
  parameter int RSP_W      = 36,
  parameter int FRAME_BITS = 500,
  parameter int BITS_W     = 14,
  parameter int BYTES_W    = 12,
  parameter int TOT_W      = 16
) (
  input  logic [NUM_STR*TAG_W-1:0]   tags,
  input  logic [NUM_STR*BITS_W-1:0]  bits,
  input  logic [NUM_STR*BYTES_W-1:0] bytes,
  output logic [NUM_STR-1:0]         emit,
  output logic                       len_err,
  output logic                       overrun
);

  localparam int MAX_BYTES = (1 << LEN_W) - 1;

  logic             ended;
  logic [TOT_W-1:0] total;

  always_comb begin
    ended   = 1'b0;
    total   = TOT_W'(RSP_W);
    emit    = '0;
    len_err = 1'b0;
    for (int i = 0; i < NUM_STR; i++) begin
      if (!ended) begin
        if (tags[i*TAG_W +: TAG_W] == '0) begin
          ended = 1'b1;
        end else if (bits[i*BITS_W +: BITS_W] != '0) begin
          if (bytes[i*BYTES_W +: BYTES_W] > BYTES_W'(MAX_BYTES)) begin
            len_err = 1'b1;
          end else begin
            emit[i] = 1'b1;
            total = total + TOT_W'(TAG_W + LEN_W)
                  + (TOT_W'(bytes[i*BYTES_W +: BYTES_W]) << 3);
          end
        end
      end
    end
    overrun = (total > TOT_W'(FRAME_BITS));
  end

endmodule

// File: rtl/sip_bit_serializer.sv
module sip_bit_serializer
  import sip_pkg::*;
#(
  parameter int NUM_STR    = 4,
  parameter int TAG_W      = 4,
  parameter int LEN_W      = 6,
  parameter int RSP_W      = 36,
  parameter int FRAME_BITS = 500,
  parameter int BITS_W     = 14,
  parameter int BYTES_W    = 12,
  parameter int DATA_W     = 504
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_start,
  input  logic [RSP_W-1:0]           rsp_word,
  input  logic [NUM_STR*TAG_W-1:0]   tags,
  input  logic [NUM_STR*BITS_W-1:0]  bits,
  input  logic [NUM_STR*BYTES_W-1:0] bytes,
  input  logic [NUM_STR*DATA_W-1:0]  data,
  input  logic [NUM_STR-1:0]         emit,
  input  logic                       len_err_in,
  input  logic                       overrun_in,
  output logic                       sdi,
  output logic                       len_err,
  output logic                       overrun
);

  localparam int CNT_W  = LEN_W + 3;
  localparam int SLOT_W = $clog2(FRAME_BITS);
  localparam int SIDX_W = (NUM_STR > 1) ? $clog2(NUM_STR) : 1;

  // frame snapshot, captured at frame start
  logic [RSP_W-1:0]  rsp_q;
  logic [TAG_W-1:0]  tag_q  [NUM_STR];
  logic [LEN_W-1:0]  len_q  [NUM_STR];
  logic [BITS_W-1:0] bits_q [NUM_STR];
  logic [DATA_W-1:0] data_q [NUM_STR];
  logic [NUM_STR-1:0] emit_q;

  phase_e            ph_q, ph_n;
  logic [CNT_W-1:0]  bcnt_q, bcnt_n;
  logic [SIDX_W-1:0] sidx_q, sidx_n;
  logic [SLOT_W-1:0] slot_q;
  logic              act_q;
  logic              sdi_q, cur_bit;
  logic              lerr_q, ovr_q;
  logic [CNT_W-1:0]  last_cnt;
  int                first_idx, after_idx;

  always_ff @(posedge clk) begin
    if (frame_start) begin
      rsp_q  <= rsp_word;
      emit_q <= emit;
      for (int i = 0; i < NUM_STR; i++) begin
        tag_q[i]  <= tags[i*TAG_W +: TAG_W];
        len_q[i]  <= bytes[i*BYTES_W +: LEN_W];
        bits_q[i] <= bits[i*BITS_W +: BITS_W];
        data_q[i] <= data[i*DATA_W +: DATA_W];
      end
    end
  end

  assign first_idx = next_set(32'(emit_q), 0, NUM_STR);
  assign after_idx = next_set(32'(emit_q), int'(sidx_q) + 1, NUM_STR);
  assign last_cnt  = CNT_W'({len_q[sidx_q], 3'b000}) - CNT_W'(1);

  always_comb begin
    cur_bit = 1'b0;
    ph_n    = ph_q;
    bcnt_n  = bcnt_q + CNT_W'(1);
    sidx_n  = sidx_q;
    unique case (ph_q)
      PH_RESP: begin
        cur_bit = rsp_q[RSP_W-1-int'(bcnt_q)];
        if (int'(bcnt_q) == RSP_W-1) begin
          bcnt_n = '0;
          if (first_idx < NUM_STR) begin
            ph_n   = PH_TAG;
            sidx_n = SIDX_W'(first_idx);
          end else begin
            ph_n = PH_FILL;
          end
        end
      end
      PH_TAG: begin
        cur_bit = tag_q[sidx_q][TAG_W-1-int'(bcnt_q)];
        if (int'(bcnt_q) == TAG_W-1) begin
          ph_n   = PH_LEN;
          bcnt_n = '0;
        end
      end
      PH_LEN: begin
        cur_bit = len_q[sidx_q][LEN_W-1-int'(bcnt_q)];
        if (int'(bcnt_q) == LEN_W-1) begin
          ph_n   = PH_DATA;
          bcnt_n = '0;
        end
      end
      PH_DATA: begin
        if (BITS_W'(bcnt_q) < bits_q[sidx_q])
          cur_bit = data_q[sidx_q][DATA_W-1-int'(bcnt_q)];
        if (bcnt_q == last_cnt) begin
          bcnt_n = '0;
          if (after_idx < NUM_STR) begin
            ph_n   = PH_TAG;
            sidx_n = SIDX_W'(after_idx);
          end else begin
            ph_n = PH_FILL;
          end
        end
      end
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_q  <= 1'b0;
      act_q  <= 1'b0;
      ph_q   <= PH_IDLE;
      slot_q <= '0;
      bcnt_q <= '0;
      sidx_q <= '0;
      lerr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (frame_start) begin
      sdi_q  <= rsp_word[RSP_W-1];
      act_q  <= 1'b1;
      ph_q   <= PH_RESP;
      slot_q <= '0;
      bcnt_q <= CNT_W'(1);
      sidx_q <= '0;
      lerr_q <= len_err_in;
      ovr_q  <= overrun_in;
    end else if (act_q) begin
      if (int'(slot_q) == FRAME_BITS-1) begin
        sdi_q <= 1'b0;
        act_q <= 1'b0;
        ph_q  <= PH_IDLE;
      end else begin
        sdi_q  <= cur_bit;
        slot_q <= slot_q + SLOT_W'(1);
        ph_q   <= ph_n;
        bcnt_q <= bcnt_n;
        sidx_q <= sidx_n;
      end
    end else begin
      sdi_q <= 1'b0;
    end
  end

  assign sdi     = sdi_q;
  assign len_err = lerr_q;
  assign overrun = ovr_q;

  assert_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act_q && slot_q == '0 && sdi_q == $past(rsp_word[RSP_W-1])));

  assert_slot_bound_R10: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (int'(slot_q) < FRAME_BITS));

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !sdi_q);

  assert_fill_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (act_q && ph_q == PH_FILL && !frame_start) |=> !sdi_q);

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q && ph_q == PH_DATA && !frame_start && BITS_W'(bcnt_q) >= bits_q[sidx_q])
      |=> !sdi_q);

  assert_sent_stream_R7: assert property (@(posedge clk) disable iff (rst)
    (act_q && ph_q == PH_TAG) |-> (len_q[sidx_q] != '0 && tag_q[sidx_q] != '0));

endmodule

// File: rtl/sdi_inbound_packer.sv
module sdi_inbound_packer #(
  parameter int NUM_STR    = 4,
  parameter int TAG_W      = 4,
  parameter int LEN_W      = 6,
  parameter int RSP_W      = 36,
  parameter int FRAME_BITS = 500,
  parameter int BLK_W      = 3,
  parameter int CH_W       = 5,
  parameter int SW_W       = 6
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  frame_start,
  input  logic [RSP_W-1:0]                      rsp_word,
  input  logic [NUM_STR*TAG_W-1:0]              strm_tag,
  input  logic [NUM_STR*SW_W-1:0]               strm_width,
  input  logic [NUM_STR*CH_W-1:0]               strm_chans,
  input  logic [NUM_STR*BLK_W-1:0]              strm_blocks,
  input  logic [NUM_STR*((1<<LEN_W)-1)*8-1:0]   strm_data,
  output logic                                  sdi,
  output logic                                  len_err,
  output logic                                  overrun
);

  localparam int DATA_W  = ((1 << LEN_W) - 1) * 8;
  localparam int BITS_W  = BLK_W + CH_W + SW_W;
  localparam int BYTES_W = BITS_W - 2;
  localparam int TOT_W   = BITS_W + $clog2(NUM_STR + 1) + 2;

  logic [NUM_STR*BITS_W-1:0]  bits_all;
  logic [NUM_STR*BYTES_W-1:0] bytes_all;
  logic [NUM_STR-1:0]         emit;
  logic                       len_err_c, overrun_c;

  for (genvar g = 0; g < NUM_STR; g++) begin : g_size
    sip_stream_sizer #(
      .BLK_W(BLK_W), .CH_W(CH_W), .SW_W(SW_W),
      .BITS_W(BITS_W), .BYTES_W(BYTES_W)
    ) u_size (
      .blocks (strm_blocks[g*BLK_W +: BLK_W]),
      .chans  (strm_chans[g*CH_W +: CH_W]),
      .width  (strm_width[g*SW_W +: SW_W]),
      .bits   (bits_all[g*BITS_W +: BITS_W]),
      .bytes  (bytes_all[g*BYTES_W +: BYTES_W])
    );
  end

  sip_frame_budget #(
    .NUM_STR(NUM_STR), .TAG_W(TAG_W), .LEN_W(LEN_W), .RSP_W(RSP_W),
    .FRAME_BITS(FRAME_BITS), .BITS_W(BITS_W), .BYTES_W(BYTES_W), .TOT_W(TOT_W)
  ) u_budget (
    .tags    (strm_tag),
    .bits    (bits_all),
    .bytes   (bytes_all),
    .emit    (emit),
    .len_err (len_err_c),
    .overrun (overrun_c)
  );

  sip_bit_serializer #(
    .NUM_STR(NUM_STR), .TAG_W(TAG_W), .LEN_W(LEN_W), .RSP_W(RSP_W),
    .FRAME_BITS(FRAME_BITS), .BITS_W(BITS_W), .BYTES_W(BYTES_W), .DATA_W(DATA_W)
  ) u_ser (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .rsp_word    (rsp_word),
    .tags        (strm_tag),
    .bits        (bits_all),
    .bytes       (bytes_all),
    .data        (strm_data),
    .emit        (emit),
    .len_err_in  (len_err_c),
    .overrun_in  (overrun_c),
    .sdi         (sdi),
    .len_err     (len_err),
    .overrun     (overrun)
  );

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(len_err) && $stable(overrun)));

endmodule

// File: tb/tb_sdi_inbound_packer.sv
module tb_sdi_inbound_packer;

  localparam int NS = 4;
  localparam int DW = 504;
  localparam int FB = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs  = 1'b0;
  logic [35:0]      rsp  = '0;
  logic [NS*4-1:0]  tagv = '0;
  logic [NS*6-1:0]  swv  = '0;
  logic [NS*5-1:0]  chv  = '0;
  logic [NS*3-1:0]  blkv = '0;
  logic [NS*DW-1:0] datv = '0;
  logic sdi, len_err, overrun;

  logic [0:FB-1] got, expf;
  logic exp_le, exp_ov, got_le, got_ov, got_idle;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sdi_inbound_packer dut (
    .clk(clk), .rst(rst), .frame_start(fs), .rsp_word(rsp),
    .strm_tag(tagv), .strm_width(swv), .strm_chans(chv), .strm_blocks(blkv),
    .strm_data(datv), .sdi(sdi), .len_err(len_err), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_stream(input int i, input int tag, input int sw, input int ch, input int blk);
    tagv[i*4 +: 4] = 4'(tag);
    swv[i*6 +: 6]  = 6'(sw);
    chv[i*5 +: 5]  = 5'(ch);
    blkv[i*3 +: 3] = 3'(blk);
  endtask

  task automatic fill_random_data();
    for (int w = 0; w < NS*DW/8; w++) datv[w*8 +: 8] = 8'($urandom);
  endtask

  // independent frame model built from the requirements
  task automatic model();
    int pos, b, nb;
    bit ended;
    expf = '0; exp_le = 0; pos = 0; ended = 0;
    for (int k = 35; k >= 0; k--) begin if (pos < FB) expf[pos] = rsp[k]; pos++; end
    for (int i = 0; i < NS; i++) begin
      if (!ended) begin
        if (tagv[i*4 +: 4] == 0) ended = 1;
        else begin
          b = int'(blkv[i*3 +: 3]) * int'(chv[i*5 +: 5]) * int'(swv[i*6 +: 6]);
          if (b > 0) begin
            nb = (b + 7) / 8;
            if (nb > 63) exp_le = 1;
            else begin
              for (int k = 3; k >= 0; k--) begin if (pos < FB) expf[pos] = tagv[i*4+k]; pos++; end
              for (int k = 5; k >= 0; k--) begin if (pos < FB) expf[pos] = nb[k]; pos++; end
              for (int k = 0; k < nb*8; k++) begin
                if (pos < FB) expf[pos] = (k < b) ? datv[i*DW + DW-1-k] : 1'b0;
                pos++;
              end
            end
          end
        end
      end
    end
    exp_ov = (pos > FB);
  endtask

  task automatic run_frame();
    model();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    got[0] = sdi; got_le = len_err; got_ov = overrun;
    for (int s = 1; s < FB; s++) begin @(negedge clk); got[s] = sdi; end
    @(negedge clk); got_idle = sdi;
  endtask

  task automatic cmp_frame(input string req);
    int bad;
    bad = -1;
    for (int s = FB-1; s >= 0; s--) if (got[s] !== expf[s]) bad = s;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s frame slot %0d actual=%b expected=%b", req, bad, got[bad], expf[bad]);
    end
  endtask

  task automatic clear_streams();
    for (int i = 0; i < NS; i++) set_stream(i, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h1DE5_0A7C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sdi", 64'(sdi), 0);
    chk("R1 len_err", 64'(len_err), 0);
    chk("R1 overrun", 64'(overrun), 0);

    // R2 R3: response then tag 5 and length 4
    rsp = 36'hA_1234_5678;
    clear_streams(); fill_random_data();
    set_stream(0, 5, 16, 2, 1);
    run_frame();
    chk("R2 response", 64'(got[0:35]), 64'(rsp));
    chk("R3 tag", 64'(got[36:39]), 64'h5);
    chk("R3 length", 64'(got[40:45]), 64'h4);
    cmp_frame("R3");

    // R4: one 8-bit sample 0xA5 MSB first
    clear_streams(); fill_random_data();
    set_stream(0, 3, 8, 1, 1);
    datv[DW-1 -: 8] = 8'hA5;
    run_frame();
    chk("R4 sample bits", 64'(got[46:53]), 64'hA5);
    cmp_frame("R4");

    // R5: 12-bit payload padded to 2 bytes, ones in data beyond payload
    clear_streams(); datv = '1;
    set_stream(0, 7, 12, 1, 1);
    set_stream(1, 9, 8, 1, 1);
    run_frame();
    chk("R5 length", 64'(got[40:45]), 64'h2);
    chk("R5 pad zero", 64'(got[58:61]), 64'h0);
    chk("R5 next tag", 64'(got[62:65]), 64'h9);
    cmp_frame("R5");

    // R6: tag 0 ends the list
    clear_streams(); fill_random_data();
    set_stream(0, 0, 8, 1, 1);
    set_stream(1, 6, 8, 2, 1);
    run_frame();
    chk("R6 no stream", 64'(got[36:99]), 64'h0);
    cmp_frame("R6");

    // R7: empty stream skipped
    clear_streams(); fill_random_data();
    set_stream(0, 4, 16, 2, 0);
    set_stream(1, 9, 16, 1, 1);
    run_frame();
    chk("R7 skipped", 64'(got[36:39]), 64'h9);
    cmp_frame("R7");

    // R8: 512-bit stream rejected
    clear_streams(); fill_random_data();
    set_stream(0, 2, 32, 16, 1);
    set_stream(1, 11, 8, 1, 1);
    run_frame();
    chk("R8 len_err", 64'(got_le), 1);
    chk("R8 dropped", 64'(got[36:39]), 64'hB);
    chk("R8 flag held", 64'(len_err), 1);
    cmp_frame("R8");

    // R10 R9: four 16-byte streams exceed the budget
    clear_streams(); fill_random_data();
    for (int i = 0; i < NS; i++) set_stream(i, i+1, 32, 4, 1);
    run_frame();
    chk("R10 overrun", 64'(got_ov), 1);
    cmp_frame("R10");
    chk("R9 idle after frame", 64'(got_idle), 0);

    // R11: restart in mid-frame
    clear_streams(); fill_random_data();
    set_stream(0, 8, 32, 2, 2);
    rsp = '1;
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    repeat (60) @(negedge clk);
    rsp = 36'h0_0F0F_3C3C;
    clear_streams(); set_stream(0, 12, 24, 1, 1);
    run_frame();
    chk("R11 restart response", 64'(got[0:35]), 64'(rsp));
    cmp_frame("R11");
    chk("R9 idle", 64'(got_idle), 0);

    // random frames
    for (int n = 0; n < 40; n++) begin
      rsp = {4'($urandom), 32'($urandom)};
      fill_random_data();
      for (int i = 0; i < NS; i++) begin
        set_stream(i, ($urandom % 10 == 0) ? 0 : 1 + $urandom % 15,
                   1 + $urandom % 32, 1 + $urandom % 4, $urandom % 3);
      end
      run_frame();
      cmp_frame("R3 R4 R5 random");
      chk("R8 random len_err", 64'(got_le), 64'(exp_le));
      chk("R10 random overrun", 64'(got_ov), 64'(exp_ov));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule